// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

A bank of eight 32-bit counters that measures request traffic arriving at a cache. Software reaches every control, selection and count through a simple single-cycle register write/read port. Counter 0 counts clock cycles. Counter 1 counts cycles in which the wasted-cycle input is high. Counters 2 and above each count cycles in which the event input vector, ANDed with that counter's own event mask, is nonzero.

To watch for a threshold, software loads a counter with all-ones minus the limit. The counter wraps past all-ones once the limit is reached, and the wrap sets that counter's overflow status bit. A shared, level-sensitive, active-high interrupt stays asserted while any status bit is set whose counter also has its interrupt enable set. The global interrupt enable must also be set. Software reads the status register and clears bits by writing ones to a separate clear register. A separate set register lets software force status bits high.

Top module: `evmon_bank`

## Requirements
- R1: After a synchronous active-low reset, all counters, control and mask registers and status bits are zero and `irq` is low. Offset 0x00 reads the fixed version 0x00010200. Offsets that are unmapped or write-only read zero.
- R2: Counter 0 (value at 0x40) adds one on every clock edge, and counter 1 (value at 0x44) adds one on every edge where `waste_in` is high. In both cases global control bit 0 (0x08) and the counter's own control bit 0 (0x100+4*i) must both be set.
- R3: A counter i ≥ 2 adds one on every edge where `event_in` AND its mask (0x140+4*i, low 16 bits) is nonzero, provided global bit 0 and its own control bit 0 are set.
- R4: Writing 0 to a counter's control register stops it, so it holds its value, and masks its interrupt contribution.
- R5: Writing a counter's value register loads that value. A load takes priority over an increment in the same cycle.
- R6: An increment from 0xFFFFFFFF gives 0 and sets status bit i (register 0x30, bit i = counter i). The counter then keeps counting.
- R7: Writing 0x34 clears each status bit whose data bit is 1, and leaves bits written with 0 unchanged. A wrap in the same cycle as a clear of that bit leaves the bit set.
- R8: Writing 0x3C sets each status bit whose data bit is 1.
- R9: Any write to 0x0C zeroes all counter values and all status bits in that cycle, while control and mask registers keep their contents.
- R10: `irq` is high exactly while global control bit 1 is set and some status bit i is set with counter i's control bit 1 set. It falls in the cycle after the last such bit is cleared.
- R11: Counters 0 and 1 have no mask register: writes to 0x140 and 0x144 are ignored, and those offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 9 | Byte address of the register to write or read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| waste_in | input | 1 | Wasted-cycle indication counted by counter 1 |
| event_in | input | 16 | Event vector matched against each counter's mask |
| irq | output | 1 | Level, active-high overflow interrupt |

## Verification
Two actions can land on the same status bit in the same cycle: a counter wrapping from all-ones, and a software write to the clear register. The test loads a counter with 0xFFFFFFFF and forces its status bit high through the set register. It then drives a matching event in the same cycle as the clear write. Afterwards the bit must still read as set and the counter must read zero. A randomized phase also loads counters to values just below all-ones while clear, set and global reset writes arrive. The same mix lets counter loads collide with increments. Every read is compared against a model built from the requirements.

// File: rtl/evmon_pkg.sv
// Shared register offsets and control-bit positions for the event counter bank.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package evmon_pkg;
    localparam int unsigned OFF_VERSION = 'h000;
    localparam int unsigned OFF_GCTL    = 'h008;
    localparam int unsigned OFF_GRST    = 'h00C;
    localparam int unsigned OFF_OVST    = 'h030;
    localparam int unsigned OFF_OVCLR   = 'h034;
    localparam int unsigned OFF_OVSET   = 'h03C;
    localparam int unsigned BASE_VAL    = 'h040;
    localparam int unsigned BASE_CTL    = 'h100;
    localparam int unsigned BASE_SEL    = 'h140;
    localparam int unsigned STRIDE      = 4;
    // bit positions shared by the global and per-counter control registers
    localparam int unsigned BIT_RUN     = 0;
    localparam int unsigned BIT_IRQ     = 1;
    // first counter index that owns an event mask
    localparam int unsigned FIRST_SEL   = 2;
endpackage

// File: rtl/evmon_decode.sv
// Write decoder: turns one bus write into one-hot strobes per register.
// Assumes a single write per cycle; mask strobes exist only for counters
// at or above FIRST_SEL, so the fixed counters' mask offsets are inert.
module evmon_decode
    import evmon_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 9
) (
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          wr_gctl,
    output logic          wr_grst,
    output logic          wr_clr,
    output logic          wr_set,
    output logic [N-1:0]  wr_val,
    output logic [N-1:0]  wr_ctl,
    output logic [N-1:0]  wr_sel
);
    // fixed-offset registers
    always_comb begin
        wr_gctl = wr && (addr == AW'(OFF_GCTL));
        wr_grst = wr && (addr == AW'(OFF_GRST));
        wr_clr  = wr && (addr == AW'(OFF_OVCLR));
        wr_set  = wr && (addr == AW'(OFF_OVSET));
    end

    // per-counter register windows
    always_comb begin
        for (int i = 0; i < N; i++) begin
            wr_val[i] = wr && (addr == AW'(BASE_VAL + STRIDE * i));
            wr_ctl[i] = wr && (addr == AW'(BASE_CTL + STRIDE * i));
            wr_sel[i] = wr && (i >= FIRST_SEL) && (addr == AW'(BASE_SEL + STRIDE * i));
        end
    end
endmodule

// File: rtl/evmon_counter.sv
// One counter with its control register. Counts when the global run bit,
// its own run bit and the qualifying hit are all high. Priority: global
// reset, then software load, then increment. Flags a wrap from all-ones.
module evmon_counter
    import evmon_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_glb,
    input  logic          grst,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    input  logic          ctl_wr,
    input  logic [1:0]    ctl_val,
    input  logic          hit,
    output logic [DW-1:0] cnt_q,
    output logic [1:0]    ctl_q,
    output logic          wrap
);
    logic inc;

    // increment qualifier and wrap detection
    always_comb begin
        inc  = run_glb && ctl_q[BIT_RUN] && hit;
        wrap = inc && !ld && (cnt_q == '1);
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n || grst) cnt_q <= '0;
        else if (ld)        cnt_q <= ld_val;
        else if (inc)       cnt_q <= cnt_q + DW'(1);
    end

    // control register (global reset leaves it alone)
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_val;
    end
endmodule

// File: rtl/evmon_ovf.sv
// Overflow status and interrupt. Clear writes drop bits, set writes and
// wraps raise them, and a wrap wins over a same-cycle clear. Global reset
// wins over everything. The interrupt is a level taken from registered status.
module evmon_ovf #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grst,
    input  logic         wr_clr,
    input  logic         wr_set,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] wrap,
    input  logic [N-1:0] irq_en,
    input  logic         glb_irq,
    output logic [N-1:0] status_q,
    output logic         irq
);
    logic [N-1:0] clr_m;
    logic [N-1:0] set_m;

    // masks from the write strobes
    always_comb begin
        clr_m = wr_clr ? wdata : '0;
        set_m = wr_set ? wdata : '0;
    end

    // status register
    always_ff @(posedge clk) begin
        if (!rst_n || grst) status_q <= '0;
        else                status_q <= (status_q & ~clr_m) | set_m | wrap;
    end

    // interrupt level
    always_comb irq = glb_irq && |(status_q & irq_en);
endmodule

// File: rtl/evmon_bank.sv
// Top of the event counter bank: global control, write decode, counters,
// event masks, overflow status and the combinational read mux.
// Assumes N_CNT*4 bytes fit in each register window and N_CNT <= DW.
module evmon_bank
    import evmon_pkg::*;
#(
    parameter int          N_CNT   = 8,
    parameter int          EV_W    = 16,
    parameter int          DW      = 32,
    parameter int          AW      = 9,
    parameter logic [31:0] VERSION = 32'h0001_0200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            waste_in,
    input  logic [EV_W-1:0] event_in,
    output logic            irq
);
    localparam int CTL_W = 2;

    logic                        wr_gctl, wr_grst, wr_clr, wr_set;
    logic [N_CNT-1:0]            wr_val, wr_ctl, wr_sel;
    logic [CTL_W-1:0]            gctl_q;
    logic [N_CNT-1:0][DW-1:0]    cnt_q;
    logic [N_CNT-1:0][CTL_W-1:0] ctl_q;
    logic [N_CNT-1:0][EV_W-1:0]  sel_q;
    logic [N_CNT-1:0]            hit, wrap_w, run_vec, ie_vec, ovf_q;

    evmon_decode #(.N(N_CNT), .AW(AW)) u_dec (
        .wr(bus_wr), .addr(bus_addr),
        .wr_gctl(wr_gctl), .wr_grst(wr_grst), .wr_clr(wr_clr), .wr_set(wr_set),
        .wr_val(wr_val), .wr_ctl(wr_ctl), .wr_sel(wr_sel)
    );

    // global control register
    always_ff @(posedge clk) begin
        if (!rst_n)       gctl_q <= '0;
        else if (wr_gctl) gctl_q <= bus_wdata[CTL_W-1:0];
    end

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        // event mask register (write strobe is never raised for fixed counters)
        always_ff @(posedge clk) begin
            if (!rst_n)        sel_q[i] <= '0;
            else if (wr_sel[i]) sel_q[i] <= bus_wdata[EV_W-1:0];
        end

        // hit source chosen by counter index
        if (i == 0) begin : g_cyc
            assign hit[i] = 1'b1;
        end else if (i == 1) begin : g_waste
            assign hit[i] = waste_in;
        end else begin : g_evt
            assign hit[i] = |(event_in & sel_q[i]);
        end

        evmon_counter #(.DW(DW)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .run_glb(gctl_q[BIT_RUN]), .grst(wr_grst),
            .ld(wr_val[i]), .ld_val(bus_wdata),
            .ctl_wr(wr_ctl[i]), .ctl_val(bus_wdata[CTL_W-1:0]),
            .hit(hit[i]),
            .cnt_q(cnt_q[i]), .ctl_q(ctl_q[i]), .wrap(wrap_w[i])
        );

        assign run_vec[i] = ctl_q[i][BIT_RUN];
        assign ie_vec[i]  = ctl_q[i][BIT_IRQ];
    end

    evmon_ovf #(.N(N_CNT)) u_ovf (
        .clk(clk), .rst_n(rst_n), .grst(wr_grst),
        .wr_clr(wr_clr), .wr_set(wr_set), .wdata(bus_wdata[N_CNT-1:0]),
        .wrap(wrap_w), .irq_en(ie_vec), .glb_irq(gctl_q[BIT_IRQ]),
        .status_q(ovf_q), .irq(irq)
    );

    // read mux: unmapped and write-only offsets give zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_VERSION)) bus_rdata = DW'(VERSION);
        if (bus_addr == AW'(OFF_GCTL))    bus_rdata = DW'(gctl_q);
        if (bus_addr == AW'(OFF_OVST))    bus_rdata = DW'(ovf_q);
        for (int i = 0; i < N_CNT; i++) begin
            if (bus_addr == AW'(BASE_VAL + STRIDE * i)) bus_rdata = cnt_q[i];
            if (bus_addr == AW'(BASE_CTL + STRIDE * i)) bus_rdata = DW'(ctl_q[i]);
            if (bus_addr == AW'(BASE_SEL + STRIDE * i)) bus_rdata = DW'(sel_q[i]);
        end
    end
endmodule

// File: rtl/evmon_bank_chk.sv
// Checker for the event counter bank: status, wrap, hold and interrupt rules.
// Attached to every evmon_bank instance by the bind at the end of this file.
module evmon_bank_chk
    import evmon_pkg::*;
#(
    parameter int N  = 8,
    parameter int DW = 32,
    parameter int AW = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic                 irq,
    input logic [N-1:0]         ovf_q,
    input logic [N-1:0]         wrap_w,
    input logic [N-1:0]         run_vec,
    input logic [N-1:0][DW-1:0] cnt_q
);
    logic grst_w, clr_w;
    assign grst_w = bus_wr && (bus_addr == AW'(OFF_GRST));
    assign clr_w  = bus_wr && (bus_addr == AW'(OFF_OVCLR));

    // R9: global reset empties counters and status
    a_r9_grst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        grst_w |=> (ovf_q == '0) && (cnt_q == '0));

    // R10: interrupt never without a status bit
    a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_q != '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic ld_w;
        assign ld_w = bus_wr && (bus_addr == AW'(BASE_VAL + STRIDE * i));

        // R6: a wrap raises the status bit and leaves zero in the counter
        a_r6_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (wrap_w[i] && !grst_w) |=> ovf_q[i] && (cnt_q[i] == '0));

        // R7: clearing a bit with no concurrent wrap drops it
        a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_w && bus_wdata[i] && !wrap_w[i]) |=> !ovf_q[i]);

        // R4: a stopped counter keeps its value
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !ld_w && !grst_w) |=> $stable(cnt_q[i]));
    end
endmodule

bind evmon_bank evmon_bank_chk #(.N(N_CNT), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .ovf_q(ovf_q), .wrap_w(wrap_w),
    .run_vec(run_vec), .cnt_q(cnt_q)
);

// File: tb/sim_evmon_bank.sv
// Bench: directed corner cases, then seeded random traffic against a model
// written from the requirements. Inputs change on the falling edge.
module sim_evmon_bank;
    localparam int N  = 8;
    localparam int EW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [8:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          waste_in = 1'b0;
    logic [EW-1:0] event_in = '0;
    logic          irq;
    int            n_run = 0;
    int            n_fail = 0;

    always #4 clk = ~clk;

    evmon_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .waste_in(waste_in),
        .event_in(event_in), .irq(irq)
    );

    // reference model
    logic [31:0]   m_cnt [N];
    logic [1:0]    m_ctl [N];
    logic [EW-1:0] m_sel [N];
    logic [1:0]    m_gctl;
    logic [N-1:0]  m_ovf;
    logic [N-1:0]  m_wrap;
    logic          m_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cnt[i] = '0; m_ctl[i] = '0; m_sel[i] = '0;
            end
            m_gctl = '0; m_ovf = '0;
        end else begin
            m_wrap = '0;
            for (int i = 0; i < N; i++) begin
                m_hit = (i == 0) ? 1'b1 : (i == 1) ? waste_in : |(event_in & m_sel[i]);
                if (bus_wr && bus_addr == 9'(64 + 4 * i)) m_cnt[i] = bus_wdata;
                else if (m_gctl[0] && m_ctl[i][0] && m_hit) begin
                    if (m_cnt[i] == 32'hFFFF_FFFF) m_wrap[i] = 1'b1;
                    m_cnt[i] = m_cnt[i] + 32'd1;
                end
            end
            if (bus_wr && bus_addr == 9'h034) m_ovf = m_ovf & ~bus_wdata[N-1:0];
            if (bus_wr && bus_addr == 9'h03C) m_ovf = m_ovf | bus_wdata[N-1:0];
            m_ovf = m_ovf | m_wrap;
            if (bus_wr && bus_addr == 9'h008) m_gctl = bus_wdata[1:0];
            for (int i = 0; i < N; i++) begin
                if (bus_wr && bus_addr == 9'(256 + 4 * i)) m_ctl[i] = bus_wdata[1:0];
                if (bus_wr && i >= 2 && bus_addr == 9'(320 + 4 * i)) m_sel[i] = bus_wdata[EW-1:0];
            end
            if (bus_wr && bus_addr == 9'h00C) begin
                for (int i = 0; i < N; i++) m_cnt[i] = '0;
                m_ovf = '0;
            end
        end
    end

    function automatic logic [31:0] mdl_read(input logic [8:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 9'h000) r = 32'h0001_0200;
        if (a == 9'h008) r = 32'(m_gctl);
        if (a == 9'h030) r = 32'(m_ovf);
        for (int i = 0; i < N; i++) begin
            if (a == 9'(64 + 4 * i))  r = m_cnt[i];
            if (a == 9'(256 + 4 * i)) r = 32'(m_ctl[i]);
            if (a == 9'(320 + 4 * i)) r = 32'(m_sel[i]);
        end
        return r;
    endfunction

    function automatic logic mdl_irq();
        logic any;
        any = 1'b0;
        for (int i = 0; i < N; i++) any = any | (m_ovf[i] & m_ctl[i][1]);
        return m_gctl[1] & any;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // compare a register read with both the model and a literal value
    task automatic rdl(input logic [8:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, mdl_read(a));
    endtask

    task automatic irqc(input logic exp, input string tag);
        #1;
        chk(tag, 32'(irq), 32'(exp));
        chk({tag, " model"}, 32'(irq), 32'(mdl_irq()));
    endtask

    function automatic logic [8:0] pick_addr(input int unsigned r);
        case (r % 9)
            0: return 9'h000;
            1: return 9'h008;
            2: return 9'h030;
            3: return 9'(64 + 4 * ((r / 9) % N));
            4: return 9'(256 + 4 * ((r / 9) % N));
            5: return 9'(320 + 4 * ((r / 9) % N));
            6: return 9'h034;
            7: return 9'h03C;
            default: return 9'h004;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        logic [31:0] held;
        seed = 32'd1234;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rdl(9'h000, 32'h0001_0200, "R1 version");
        rdl(9'h004, 32'h0, "R1 unmapped");
        rdl(9'h048, 32'h0, "R1 counter2 zero");
        rdl(9'h030, 32'h0, "R1 status zero");
        irqc(1'b0, "R1 irq low");

        // R2: cycle and wasted-cycle counters
        wr(9'h008, 32'h3);
        wr(9'h100, 32'h1);
        wr(9'h104, 32'h1);
        waste_in = 1'b1;
        repeat (5) @(negedge clk);
        waste_in = 1'b0;
        repeat (2) @(negedge clk);
        rdl(9'h044, 32'd5, "R2 wasted count");
        bus_addr = 9'h040; #1;
        chk("R2 cycle counter running", 32'(bus_rdata > 32'd8), 32'd1);
        chk("R2 cycle model", bus_rdata, mdl_read(9'h040));

        // R3: masked events on counter 2
        wr(9'h148, 32'h0005);
        wr(9'h108, 32'h3);
        event_in = 16'h0002;
        repeat (3) @(negedge clk);
        event_in = 16'h0004;
        repeat (4) @(negedge clk);
        event_in = 16'h0000;
        rdl(9'h048, 32'd4, "R3 masked events");

        // R5: load beats a same-cycle increment
        event_in = 16'h0004;
        wr(9'h048, 32'hFFFF_FFFD);
        rdl(9'h048, 32'hFFFF_FFFD, "R5 load wins");
        // R6: wrap after the preload
        repeat (3) @(negedge clk);
        event_in = 16'h0000;
        rdl(9'h048, 32'h0, "R6 wrapped to zero");
        rdl(9'h030, 32'h4, "R6 status bit2");
        irqc(1'b1, "R10 irq raised");
        event_in = 16'h0004;
        repeat (2) @(negedge clk);
        event_in = 16'h0000;
        rdl(9'h048, 32'd2, "R6 keeps counting");

        // R7: zero bits ignored, one bits clear, irq drops
        wr(9'h034, 32'h0);
        rdl(9'h030, 32'h4, "R7 zero clear ignored");
        wr(9'h034, 32'h4);
        rdl(9'h030, 32'h0, "R7 bit cleared");
        irqc(1'b0, "R10 irq dropped");

        // R8 and R7 collision: wrap in the same cycle as a clear
        wr(9'h14C, 32'h0002);
        wr(9'h10C, 32'h1);
        wr(9'h04C, 32'hFFFF_FFFF);
        wr(9'h03C, 32'h8);
        rdl(9'h030, 32'h8, "R8 forced bit3");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 9'h034; bus_wdata = 32'h8; event_in = 16'h0002;
        @(negedge clk);
        bus_wr = 1'b0; event_in = 16'h0000;
        rdl(9'h030, 32'h8, "R7 wrap beats clear");
        rdl(9'h04C, 32'h0, "R7 counter3 wrapped");
        irqc(1'b0, "R10 masked by counter irq enable");

        // R4: stop holds value and masks interrupt
        wr(9'h108, 32'h0);
        rdl(9'h048, 32'd2, "R4 before stop");
        event_in = 16'h0004;
        repeat (3) @(negedge clk);
        event_in = 16'h0000;
        rdl(9'h048, 32'd2, "R4 held");
        wr(9'h03C, 32'h4);
        irqc(1'b0, "R4 irq masked");

        // R11: fixed counters have no mask
        wr(9'h140, 32'hFFFF);
        rdl(9'h140, 32'h0, "R11 mask0 ignored");
        wr(9'h144, 32'hFFFF);
        rdl(9'h144, 32'h0, "R11 mask1 ignored");
        rdl(9'h040, mdl_read(9'h040), "R11 counter0 unaffected");

        // R9: global reset keeps controls
        wr(9'h00C, 32'h0);
        rdl(9'h040, 32'h0, "R9 counter0 cleared");
        rdl(9'h04C, 32'h0, "R9 counter3 cleared");
        rdl(9'h030, 32'h0, "R9 status cleared");
        rdl(9'h100, 32'h1, "R9 ctl kept");
        rdl(9'h148, 32'h5, "R9 mask kept");

        // randomized traffic against the model
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            r = $urandom();
            event_in = EW'($urandom());
            waste_in = r[20];
            bus_wr = 1'b0;
            bus_addr = pick_addr($urandom());
            if (r[3:0] < 4'd6) begin
                bus_wr = 1'b1;
                case (r[7:4])
                    4'd0, 4'd1, 4'd2, 4'd3: begin
                        bus_addr = 9'(64 + 4 * r[10:8]);
                        bus_wdata = r[11] ? (32'hFFFF_FFF0 | 32'(r[15:12])) : $urandom();
                    end
                    4'd4, 4'd5: begin bus_addr = 9'(256 + 4 * r[10:8]); bus_wdata = 32'(r[13:12]); end
                    4'd6, 4'd7: begin bus_addr = 9'(320 + 4 * r[10:8]); bus_wdata = 32'(r[31:16]); end
                    4'd8:       begin bus_addr = 9'h008; bus_wdata = r[13] ? 32'h3 : 32'(r[12:11]); end
                    4'd9, 4'd10: begin bus_addr = 9'h034; bus_wdata = 32'(r[31:24]); end
                    4'd11, 4'd12: begin bus_addr = 9'h03C; bus_wdata = 32'(r[31:24]); end
                    4'd13: begin bus_addr = r[14] ? 9'h00C : 9'h000; bus_wdata = $urandom(); end
                    default: begin bus_wr = 1'b0; end
                endcase
            end
            #1;
            chk("R3 random read", bus_rdata, mdl_read(bus_addr));
            chk("R10 random irq", 32'(irq), 32'(mdl_irq()));
        end
        @(negedge clk);
        bus_wr = 1'b0;
        held = mdl_read(9'h030);
        rdl(9'h030, held, "R7 final status");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule